// File: doc/BRIEF.md
# Programmable Video Line Delay Bank

This block holds the previous video lines that a vertical image filter needs. Seven 12-bit line delays are chained behind a registered main input. Each delay lasts one programmable line time, so the eight tap outputs carry the same pixel column from eight successive lines. An eighth delay sits in a separate path fed from a second input port, which supports filtering of odd and even fields. A cascade output carries the last delayed line on to a following bank, so a longer filter can be built from several banks.

Software-side configuration uses a small address/data/write-strobe port with three registers: line length, mode, and cascade. All delays share one read/write pointer into one wide circular memory. That pointer wraps at the programmed depth and restarts whenever the length is written. After a length write, the tap contents are meaningless until one full line has passed through. Data moves only on cycles where the clock enable is high. In recirculate mode a stored line can be read again and again. In parallel preload mode all seven main delays are filled from the input at once.

Top module: `vline_bank`

## Requirements
- R1: A synchronous reset drives every tap, the field tap and the cascade output to zero, and leaves the bank in delay mode with length value 0 and cascade shortening off.
- R2: A write with `cfgWe` high takes effect at that clock edge. Address 0 sets the length value N. Address 1 sets the mode register: bit 0 recirculate, bit 1 parallel preload, bit 2 field port enable, bit 3 field delay enable. Address 2 bit 0 sets cascade shortening.
- R3: `taps[0]` is `din` registered on an enabled edge. `taps[k]` for k = 1..7 equals `taps[k-1]` delayed by N+4 enabled edges.
- R4: A length value above 3072 is clamped to 3072, which gives a line delay of 3076 enabled edges.
- R5: On a cycle where `ce` is low, no tap, field or cascade output changes, and `din` and `fieldIn` are ignored.
- R6: In recirculate mode each delay takes its own output as its input. Each tap then repeats the last line it held, with a period equal to that delay's length, whatever `din` carries.
- R7: In parallel preload mode all seven main delays take `taps[0]` as their input, so every `taps[k]` for k ≥ 1 equals `taps[0]` delayed by one line. Preload takes priority over recirculate.
- R8: With the field port disabled, `fieldTap` is zero and `fieldIn` is ignored. With the port enabled and the field delay off, `fieldTap` is `fieldIn` registered on an enabled edge. With both enabled, that registered value is further delayed by N+4 enabled edges, and this holds in preload mode as well.
- R9: `cascadeOut` equals `taps[7]` delayed by one enabled edge.
- R10: With cascade shortening on, the first delay is N+2 enabled edges, so `taps[1]` equals `taps[0]` delayed by N+2. The other delays are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all data movement |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgData | input | CFG_W (12) | Configuration write data |
| din | input | DATA_W (12) | Main pixel input |
| fieldIn | input | DATA_W (12) | Second-field pixel input |
| taps | output | (NUM_BUF+1) x DATA_W | Line taps; index 0 is the current line |
| fieldTap | output | DATA_W | Second-field path output |
| cascadeOut | output | DATA_W | Last delayed line for a following bank |

## Verification
The bench works through the extreme lengths: value 0 (four-edge delay), value 1, and an out-of-range write clamped to 3072. If the offset or the pointer wrap were off by one, every tap would slide by one sample per stage, and a missing clamp would leave the pointer running past the last line. Clock-enable gaps with junk on the inputs expose a design whose pointer or pipeline registers move without `ce`. The recirculate switch catches delays that keep pulling new data. Preload and cascade shortening runs catch a field delay fed from the wrong port, or a first stage that is off by two and would misalign downstream banks.

// File: rtl/vline_bank_pkg.sv
package vline_bank_pkg;

  localparam logic [1:0] ADDR_LENGTH = 2'd0;
  localparam logic [1:0] ADDR_MODE   = 2'd1;
  localparam logic [1:0] ADDR_CASC   = 2'd2;

  localparam int MODE_RECIRC  = 0;
  localparam int MODE_PRELOAD = 1;
  localparam int MODE_FIELD   = 2;
  localparam int MODE_FLDBUF  = 3;

  typedef struct packed {
    logic step;        // data advances this cycle
    logic recirc;
    logic preload;
    logic fieldEn;
    logic fieldBufEn;
    logic cascade;
  } lbCtrl_t;

endpackage

// File: rtl/vline_bank_ctrl.sv
module vline_bank_ctrl
  import vline_bank_pkg::*;
#(
  parameter int CFG_W   = 12,
  parameter int MAX_LEN = 3072,
  parameter int PTR_W   = 12
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [CFG_W-1:0] cfgData,
  output lbCtrl_t          ctrl,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [CFG_W-1:0] LEN_CAP = CFG_W'(MAX_LEN);

  logic [CFG_W-1:0] lenReg;
  logic [3:0]       modeReg;
  logic             cascReg;
  logic             lenWr;
  logic [PTR_W-1:0] lastPtr;

  assign lenWr   = cfgWe && (cfgAddr == ADDR_LENGTH);
  assign lastPtr = PTR_W'(lenReg);

  always_ff @(posedge clk) begin
    if (rst) begin
      lenReg  <= '0;
      modeReg <= '0;
      cascReg <= 1'b0;
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_LENGTH: lenReg  <= (cfgData > LEN_CAP) ? LEN_CAP : cfgData;
        ADDR_MODE:   modeReg <= cfgData[3:0];
        ADDR_CASC:   cascReg <= cfgData[0];
        default: ;
      endcase
    end
  end

  // Shared pointer: depth is lenReg+1 words, restarted by a length write.
  always_ff @(posedge clk) begin
    if (rst || lenWr) ptr <= '0;
    else if (ce)      ptr <= (ptr == lastPtr) ? '0 : ptr + 1'b1;
  end

  always_comb begin
    ctrl.step       = ce;
    ctrl.recirc     = modeReg[MODE_RECIRC];
    ctrl.preload    = modeReg[MODE_PRELOAD];
    ctrl.fieldEn    = modeReg[MODE_FIELD];
    ctrl.fieldBufEn = modeReg[MODE_FLDBUF];
    ctrl.cascade    = cascReg;
  end

  // R4
  len_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    lenReg <= LEN_CAP);

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= lastPtr);

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce && !lenWr) |=> $stable(ptr));

endmodule

// File: rtl/vline_bank_dp.sv
module vline_bank_dp
  import vline_bank_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int NUM_BUF = 7,
  parameter int DEPTH   = 3073,
  parameter int PTR_W   = 12
)(
  input  logic                          clk,
  input  logic                          rst,
  input  lbCtrl_t                       ctrl,
  input  logic [PTR_W-1:0]              ptr,
  input  logic [DATA_W-1:0]             din,
  input  logic [DATA_W-1:0]             fieldIn,
  output logic [NUM_BUF:0][DATA_W-1:0]  taps,
  output logic [DATA_W-1:0]             fieldTap,
  output logic [DATA_W-1:0]             cascadeOut
);

  localparam int LANES = NUM_BUF + 1;   // lane NUM_BUF is the field path
  localparam int FLD   = NUM_BUF;

  logic [DATA_W-1:0] dinReg, fieldReg, coutReg;
  logic [LANES-1:0][DATA_W-1:0] inSel, preReg, memIn, rdReg, postReg, bufOut;
  logic [LANES-1:0][DATA_W-1:0] mem [DEPTH];

  // Lane input selection and first-stage shortening
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == FLD) begin : g_field
      assign inSel[k] = (ctrl.recirc && !ctrl.preload) ? bufOut[k]
                      : ctrl.fieldEn ? fieldReg : dinReg;
    end else if (k == 0) begin : g_first
      assign inSel[k] = ctrl.preload ? dinReg
                      : ctrl.recirc ? bufOut[k] : dinReg;
    end else begin : g_mid
      assign inSel[k] = ctrl.preload ? dinReg
                      : ctrl.recirc ? bufOut[k] : bufOut[k-1];
    end

    if (k == 0) begin : g_short
      assign memIn[k]  = ctrl.cascade ? inSel[k] : preReg[k];
      assign bufOut[k] = ctrl.cascade ? rdReg[k] : postReg[k];
    end else begin : g_plain
      assign memIn[k]  = preReg[k];
      assign bufOut[k] = postReg[k];
    end
  end

  // Wide circular memory: one word holds every lane
  always_ff @(posedge clk) begin
    if (ctrl.step) mem[ptr] <= memIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dinReg   <= '0;
      fieldReg <= '0;
      coutReg  <= '0;
      preReg   <= '0;
      rdReg    <= '0;
      postReg  <= '0;
    end else if (ctrl.step) begin
      dinReg   <= din;
      fieldReg <= fieldIn;
      coutReg  <= bufOut[NUM_BUF-1];
      preReg   <= inSel;
      rdReg    <= mem[ptr];
      postReg  <= rdReg;
    end
  end

  assign taps[0] = dinReg;
  for (genvar t = 1; t <= NUM_BUF; t++) begin : g_tap
    assign taps[t] = bufOut[t-1];
  end

  assign fieldTap   = !ctrl.fieldEn ? '0 : (ctrl.fieldBufEn ? bufOut[FLD] : fieldReg);
  assign cascadeOut = coutReg;

  // R5
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.step |=> ($stable(postReg) && $stable(rdReg) && $stable(dinReg)));

  // R7
  preload_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.step && ctrl.preload) |=> (preReg[0] == preReg[NUM_BUF-1]));

endmodule

// File: rtl/vline_bank.sv
module vline_bank
  import vline_bank_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int NUM_BUF = 7,
  parameter int MAX_LEN = 3072,
  parameter int CFG_W   = 12
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ce,
  input  logic                         cfgWe,
  input  logic [1:0]                   cfgAddr,
  input  logic [CFG_W-1:0]             cfgData,
  input  logic [DATA_W-1:0]            din,
  input  logic [DATA_W-1:0]            fieldIn,
  output logic [NUM_BUF:0][DATA_W-1:0] taps,
  output logic [DATA_W-1:0]            fieldTap,
  output logic [DATA_W-1:0]            cascadeOut
);

  localparam int DEPTH = MAX_LEN + 1;
  localparam int PTR_W = $clog2(DEPTH);

  lbCtrl_t          ctrl;
  logic [PTR_W-1:0] ptr;

  vline_bank_ctrl #(.CFG_W(CFG_W), .MAX_LEN(MAX_LEN), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst(rst), .ce(ce), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .ctrl(ctrl), .ptr(ptr)
  );

  vline_bank_dp #(.DATA_W(DATA_W), .NUM_BUF(NUM_BUF), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .ptr(ptr), .din(din), .fieldIn(fieldIn),
    .taps(taps), .fieldTap(fieldTap), .cascadeOut(cascadeOut)
  );

endmodule

// File: tb/sim_vline_bank.sv
module sim_vline_bank;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DW = 12;
  localparam int NB = 7;
  localparam int ML = 3072;

  logic clk = 1'b0;
  logic rst, ce, cfgWe;
  logic [1:0] cfgAddr;
  logic [DW-1:0] cfgData, din, fieldIn;
  logic [NB:0][DW-1:0] taps;
  logic [DW-1:0] fieldTap, cascadeOut;

  int compared = 0;
  int mismatched = 0;

  // reference state
  int lenN = 0;
  bit cascMode = 0, recMode = 0, preMode = 0, fldEn = 0, fldBuf = 0;
  int switchIdx = 1 << 30;
  int seed = 17;
  int stepIdx = -1;

  always #4 clk = ~clk;   // 125 MHz

  vline_bank u0 (
    .clk(clk), .rst(rst), .ce(ce), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .din(din), .fieldIn(fieldIn), .taps(taps),
    .fieldTap(fieldTap), .cascadeOut(cascadeOut)
  );

  function automatic logic [DW-1:0] pat(int i);
    return DW'((i * 1103 + seed) % 4096);
  endfunction

  function automatic logic [DW-1:0] fpat(int i);
    return DW'((i * 613 + seed * 3 + 91) % 4096);
  endfunction

  function automatic int lineLen(int b);
    return (b == 0 && cascMode) ? lenN + 2 : lenN + 4;
  endfunction

  // pattern index seen at tap k after enabled edge n (negative: not yet valid)
  function automatic int srcIdx(int k, int n);
    int j = n;
    if (k == 0) return n;
    if (preMode) return n - lineLen(k - 1);
    for (int b = k - 1; b >= 0; b--) begin
      int len = lineLen(b);
      j = j - len;
      if (recMode) while (j >= switchIdx) j = j - len;
    end
    return j;
  endfunction

  function automatic int fieldIdx(int n);
    int j;
    if (!fldBuf) return n;
    j = n - (lenN + 4);
    if (recMode && !preMode) while (j >= switchIdx) j = j - (lenN + 4);
    return j;
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s at step %0d: got %h expected %h", req, what, stepIdx, got, exp);
    end
  endtask

  task automatic checkAll(string req);
    int idx;
    for (int k = 0; k <= NB; k++) begin
      idx = srcIdx(k, stepIdx);
      if (idx >= 0) chk(req, $sformatf("tap%0d", k), taps[k], pat(idx));
    end
    if (stepIdx >= 1) begin
      idx = srcIdx(NB, stepIdx - 1);
      if (idx >= 0) chk(req, "cascadeOut", cascadeOut, pat(idx));
    end
    if (!fldEn) chk(req, "fieldTap", fieldTap, '0);
    else begin
      idx = fieldIdx(stepIdx);
      if (idx >= 0) chk(req, "fieldTap", fieldTap, fpat(idx));
    end
  endtask

  // one cycle; entered and left at a falling edge
  task automatic stepCycle(bit doCe, string req);
    if (doCe) begin
      din = pat(stepIdx + 1);
      fieldIn = fpat(stepIdx + 1);
    end else begin
      din = DW'(stepIdx * 7 + 5) ^ 12'hA5A;
      fieldIn = ~din;
    end
    ce = doCe;
    @(posedge clk);
    if (doCe) stepIdx++;
    @(negedge clk);
    ce = 1'b0;
    checkAll(req);
  endtask

  task automatic cfgWrite(logic [1:0] a, logic [DW-1:0] d);
    ce = 1'b0; cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic restart(int n, int sd);
    cfgWrite(2'd0, DW'(n));
    lenN = (n > ML) ? ML : n;
    stepIdx = -1;
    seed = sd;
    switchIdx = 1 << 30;
  endtask

  task automatic setMode(bit rc, bit pl, bit fe, bit fb);
    cfgWrite(2'd1, {8'd0, fb, fe, pl, rc});
    recMode = rc; preMode = pl; fldEn = fe; fldBuf = fb;
  endtask

  task automatic t_reset();
    for (int k = 0; k <= NB; k++) chk("R1", $sformatf("tap%0d", k), taps[k], '0);
    chk("R1", "fieldTap", fieldTap, '0);
    chk("R1", "cascadeOut", cascadeOut, '0);
  endtask

  task automatic t_default();   // no config writes: length 0, delay mode
    for (int i = 0; i < 60; i++) stepCycle(1'b1, "R1/R3/R9");
  endtask

  task automatic t_gaps();
    restart(1, 301);
    for (int i = 0; i < 90; i++) stepCycle((i % 3) != 2, "R2/R3/R5");
  endtask

  task automatic t_recirc();
    restart(2, 733);
    for (int i = 0; i < 60; i++) stepCycle(1'b1, "R3");
    setMode(1'b1, 1'b0, 1'b0, 1'b0);
    switchIdx = stepIdx;
    for (int i = 0; i < 50; i++) stepCycle((i % 5) != 4, "R6");
    setMode(1'b0, 1'b0, 1'b0, 1'b0);
    switchIdx = 1 << 30;
  endtask

  task automatic t_preload();
    restart(3, 1201);
    setMode(1'b1, 1'b1, 1'b1, 1'b1);   // preload overrides recirculate
    for (int i = 0; i < 30; i++) stepCycle(1'b1, "R7/R8");
    setMode(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_field();
    restart(0, 2011);
    setMode(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) stepCycle(1'b1, "R8");
    setMode(1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) stepCycle(1'b1, "R8");
    setMode(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) stepCycle(1'b1, "R8");
  endtask

  task automatic t_cascade();
    cfgWrite(2'd2, 12'd1);
    cascMode = 1;
    restart(5, 2503);
    for (int i = 0; i < 90; i++) stepCycle(1'b1, "R10/R9");
    cfgWrite(2'd2, 12'd0);
    cascMode = 0;
  endtask

  task automatic t_maxlen();
    restart(4095, 3331);   // clamps to 3072
    for (int i = 0; i < 7 * (ML + 4) + 40; i++) stepCycle(1'b1, "R4");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst = 1'b1; ce = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0;
    din = '0; fieldIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_default();
    t_gaps();
    t_recirc();
    t_preload();
    t_field();
    t_cascade();
    t_maxlen();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule